// File: doc/BRIEF.md
# Byte-Checked Serial Command Port

This block is a full-duplex serial slave port in SPI mode 0 for a controller with several output channels. It has an active-low select. When the select falls, the port takes a status byte from the fault logic into its shift register. It then sends that byte out, most significant bit first. On the same serial clocks it shifts the bits on the data input into the same register.

When the select rises, the port checks how many serial clocks arrived during the frame. It commits the last eight received bits to a command register only when that count is a non-zero whole number of bytes. Any other frame leaves the command register as it was.

Because the shift register forwards what it receives, several ports can be chained: each one sends its own status in the first byte and after that passes on what it has received. A sleep input forces the command register to zero while the select is high. Serial clock, select and data are synchronized into the system clock and edge-detected there. Each channel's enable is the OR of its bit in the command register and its discrete pin.

Top module: `spi_byte_port`

## Requirements
- R1: The first system clock cycle in which the synchronized select is seen falling loads `status_in` into the shift register and raises `status_cap` high for exactly that one cycle. The first bit driven on `sdo` is bit 7 of the captured byte.
- R2: While the select is low, the data input is sampled at each rising serial clock edge. At each falling serial clock edge the register shifts one place toward its MSB and the sampled bit enters at bit 0. `sdo` always shows bit 7.
- R3: At a select rise after a frame of 8·k serial clocks (k ≥ 1), and with sleep low, `cmd_reg` takes the last eight received bits. `cmd_valid` pulses for one cycle in the same cycle that `cmd_reg` changes.
- R4: A frame of zero clocks, or of a clock count that is not a multiple of eight, leaves `cmd_reg` unchanged and gives no `cmd_valid` pulse.
- R5: While the select is high, `sdo_oe` is 0, and serial clock and data input have no effect on the shift register or on `cmd_reg`.
- R6: In a frame of 16 clocks, the first eight bits out are the status byte and the next eight are the first received byte. `cmd_reg` then takes the second received byte.
- R7: While `sleep` is 1 and the synchronized select is high, `cmd_reg` is loaded with zero. This takes priority over committing a frame, and no `cmd_valid` pulse is given.
- R8: `chan_en[i]` equals `cmd_reg[i]` OR `pin_en[i]` for every channel i below NUM_CH.
- R9: After reset, `cmd_reg` is zero, `sdo_oe` is 0, and `cmd_valid` and `status_cap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep mode request (system clock domain) |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial clock, idle low (asynchronous) |
| sdi | input | 1 | Serial data in (asynchronous) |
| sdo | output | 1 | Serial data out, bit 7 of the shift register |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| status_in | input | BYTE_W | Status byte offered by the fault logic |
| status_cap | output | 1 | One-cycle pulse when the status byte is captured (read-to-clear) |
| pin_en | input | NUM_CH | Discrete per-channel enable pins |
| cmd_reg | output | BYTE_W | Committed command byte |
| cmd_valid | output | 1 | One-cycle pulse when a new command byte is committed |
| chan_en | output | NUM_CH | Effective channel enables |

## Verification
Some rules are checked by assertions on every cycle:
- a select fall loads the status byte;
- a falling serial clock moves the sampled bit into bit 0;
- the shift register stays frozen while the select is high;
- a partial frame leaves the command register alone;
- sleep with the select high zeroes the command register;
- the commit strobe never lasts more than one cycle.

Other behaviour can only be shown by the bench's frames, which are checked against a bit-level model:
- the order of the bits on the wire;
- the pass-through delay in a daisy chain;
- the count rule over frames of 0, 5, 8, 12 and 16 clocks;
- the effect of sleep on a frame that ends while sleep is asserted.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // Synchronized pin events, one system clock cycle wide.
  typedef struct packed {
    logic cs_low;
    logic cs_fall;
    logic cs_rise;
    logic sck_rise;
    logic sck_fall;
    logic sdi;
  } spi_evt_t;

  // Next bit position inside a byte, wrapping at the byte width.
  function automatic int unsigned bit_pos_next(input int unsigned pos,
                                               input int unsigned width);
    return (pos + 1 == width) ? 0 : pos + 1;
  endfunction

  // A frame is whole when the position is back at zero and a full byte was seen.
  function automatic logic frame_is_whole(input int unsigned pos,
                                          input logic seen_byte);
    return (pos == 0) && seen_byte;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
  import spi_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     sclk,
  input  logic     sdi,
  output spi_evt_t evt
);
  localparam int NSIG = 3;
  // Idle pin levels in the order {select, clock, data}.
  localparam logic [NSIG-1:0] IDLE = 3'b100;

  logic [NSIG-1:0] pins;
  logic [NSIG-1:0] chain [STAGES];
  logic [NSIG-1:0] synced;
  logic [1:0]      last_q;   // {select, clock} one cycle older

  assign pins = {cs_n, sclk, sdi};

  for (genvar g = 0; g < STAGES; g++) begin : gen_stage
    if (g == 0) begin : gen_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= IDLE;
        else        chain[g] <= pins;
      end
    end else begin : gen_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= IDLE;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE[2:1];
    else        last_q <= synced[2:1];
  end

  assign evt.cs_low   = !synced[2];
  assign evt.cs_fall  = last_q[1] && !synced[2];
  assign evt.cs_rise  = !last_q[1] && synced[2];
  assign evt.sck_rise = !last_q[0] && synced[1];
  assign evt.sck_fall = last_q[0] && !synced[1];
  assign evt.sdi      = synced[0];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_fall,
  input  logic         cs_low,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         sdi_s,
  input  logic [W-1:0] status_in,
  output logic [W-1:0] sh_q,
  output logic         sdo,
  output logic         status_cap,
  output logic         whole
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic             rx_bit_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             take_bit;
  logic             move_bit;

  assign take_bit = cs_low && !cs_fall && sck_rise;
  assign move_bit = cs_low && !cs_fall && sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_bit_q <= 1'b0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
    end else if (cs_fall) begin
      sh_q   <= status_in;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (take_bit) begin
        rx_bit_q <= sdi_s;
        cnt_q    <= CNT_W'(bit_pos_next(32'(cnt_q), W));
        if (32'(cnt_q) == W - 1) seen_q <= 1'b1;
      end
      if (move_bit) sh_q <= {sh_q[W-2:0], rx_bit_q};
    end
  end

  assign whole      = frame_is_whole(32'(cnt_q), seen_q);
  assign status_cap = cs_fall;
  assign sdo        = sh_q[W-1];

  // R1: a select fall loads the status byte
  p_load_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sh_q == $past(status_in));

  // R2: a falling serial clock moves the sampled bit into bit 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && cs_low && !cs_fall) |=> sh_q[0] == $past(rx_bit_q));

  // R5: the shift register is frozen while the select is high
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> $stable(sh_q));

endmodule

// File: rtl/spi_cmd_hold.sv
module spi_cmd_hold #(
  parameter int W      = 8,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_rise,
  input  logic              cs_low,
  input  logic              whole,
  input  logic [W-1:0]      sh_q,
  input  logic [NUM_CH-1:0] pin_en,
  output logic [W-1:0]      cmd_q,
  output logic              cmd_valid,
  output logic [NUM_CH-1:0] chan_en
);
  logic commit;
  logic sleep_clear;

  assign sleep_clear = sleep && !cs_low;
  assign commit      = cs_rise && whole && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
    end else begin
      if (sleep_clear) cmd_q <= '0;
      else if (commit) cmd_q <= sh_q;
      cmd_valid <= commit;
    end
  end

  assign chan_en = cmd_q[NUM_CH-1:0] | pin_en;

  // R3: a committed frame lands the shift register contents
  p_commit_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && whole && !sleep) |=> cmd_q == $past(sh_q));

  // R3: the commit strobe lasts a single cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R4: a partial frame leaves the command byte alone
  p_reject_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !whole && !sleep) |=> $stable(cmd_q));

  // R7: sleep with the select high zeroes the command byte
  p_sleep_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !cs_low) |=> (cmd_q == '0) && !cmd_valid);

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [BYTE_W-1:0] status_in,
  output logic              status_cap,
  input  logic [NUM_CH-1:0] pin_en,
  output logic [BYTE_W-1:0] cmd_reg,
  output logic              cmd_valid,
  output logic [NUM_CH-1:0] chan_en
);
  spi_evt_t          evt;
  logic [BYTE_W-1:0] sh_q;
  logic              whole;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .sdi   (sdi),
    .evt   (evt)
  );

  spi_shift_core #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (evt.cs_fall),
    .cs_low     (evt.cs_low),
    .sck_rise   (evt.sck_rise),
    .sck_fall   (evt.sck_fall),
    .sdi_s      (evt.sdi),
    .status_in  (status_in),
    .sh_q       (sh_q),
    .sdo        (sdo),
    .status_cap (status_cap),
    .whole      (whole)
  );

  spi_cmd_hold #(.W(BYTE_W), .NUM_CH(NUM_CH)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .cs_rise   (evt.cs_rise),
    .cs_low    (evt.cs_low),
    .whole     (whole),
    .sh_q      (sh_q),
    .pin_en    (pin_en),
    .cmd_q     (cmd_reg),
    .cmd_valid (cmd_valid),
    .chan_en   (chan_en)
  );

  assign sdo_oe = evt.cs_low;

endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic [3:0] pin_en = 4'h0;
  logic       sdo, sdo_oe, status_cap, cmd_valid;
  logic [7:0] cmd_reg;
  logic [3:0] chan_en;

  int  errors = 0, checks = 0, cap_n = 0, val_n = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  spi_byte_port u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in),
    .status_cap(status_cap), .pin_en(pin_en), .cmd_reg(cmd_reg),
    .cmd_valid(cmd_valid), .chan_en(chan_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model: pin history queue {cs,sclk,sdi}, integer bit count.
  logic [2:0] hist[$];
  logic [7:0] m_tx, m_cmd;
  logic       m_pend, m_valid;
  int         m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b100, 3'b100, 3'b100};
      m_tx = 0; m_cmd = 0; m_pend = 0; m_valid = 0; m_cnt = 0;
    end else begin
      logic [2:0] s, p;
      s = hist[1]; p = hist[2];
      m_valid = 0;
      if (sleep && s[2]) m_cmd = 0;
      else if (s[2] && !p[2] && m_cnt > 0 && m_cnt % 8 == 0) begin
        m_cmd = m_tx; m_valid = 1;
      end
      if (!s[2]) begin
        if (p[2]) begin m_tx = status_in; m_cnt = 0; end
        else if (s[1] && !p[1]) begin m_cnt++; m_pend = s[0]; end
        else if (!s[1] && p[1]) m_tx = {m_tx[6:0], m_pend};
      end
      hist.push_front({cs_n, sclk, sdi});
      void'(hist.pop_back());
    end
  end

  // Compare with the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && hist.size() == 3) begin
      check(cmd_reg == m_cmd, "R3", "cmd_reg", cmd_reg, m_cmd);
      check(cmd_valid == m_valid, "R3", "cmd_valid", cmd_valid, m_valid);
      check(status_cap == (hist[2][2] && !hist[1][2]), "R1", "status_cap",
            status_cap, hist[2][2] && !hist[1][2]);
      check(sdo_oe == !hist[1][2], "R5", "sdo_oe", sdo_oe, !hist[1][2]);
      if (sdo_oe) check(sdo == m_tx[7], "R2", "sdo", sdo, m_tx[7]);
      check(chan_en == (m_cmd[3:0] | pin_en), "R8", "chan_en", chan_en,
            m_cmd[3:0] | pin_en);
      if (status_cap) cap_n++;
      if (cmd_valid) val_n++;
    end
  end

  task automatic frame(input int nbits, input logic [31:0] data,
                       output logic [31:0] got);
    got = 0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      repeat (H) @(negedge clk);
      got = {got[30:0], sdo};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] got;
    int c0, v0;
    repeat (3) @(negedge clk);
    check(cmd_reg == 0, "R9", "reset cmd_reg", cmd_reg, 0);
    check(sdo_oe == 0, "R9", "reset sdo_oe", sdo_oe, 0);
    check(!cmd_valid && !status_cap, "R9", "reset strobes",
          cmd_valid | status_cap, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3: single byte
    status_in = 8'h3C; c0 = cap_n; v0 = val_n;
    frame(8, 32'hA5, got);
    check(got[7:0] == 8'h3C, "R1", "status out", got[7:0], 8'h3C);
    check(cap_n == c0 + 1, "R1", "capture pulses", cap_n - c0, 1);
    check(cmd_reg == 8'hA5, "R3", "cmd byte", cmd_reg, 8'hA5);
    check(val_n == v0 + 1, "R3", "valid pulses", val_n - v0, 1);

    // R2: another pattern
    status_in = 8'h81;
    frame(8, 32'h5A, got);
    check(got[7:0] == 8'h81, "R2", "bit order", got[7:0], 8'h81);
    check(cmd_reg == 8'h5A, "R2", "received byte", cmd_reg, 8'h5A);

    // R4: 5, 0 and 12 clocks are rejected
    v0 = val_n;
    frame(5, 32'h1F, got);
    check(cmd_reg == 8'h5A, "R4", "5-clock frame", cmd_reg, 8'h5A);
    frame(0, 32'h0, got);
    check(cmd_reg == 8'h5A, "R4", "empty frame", cmd_reg, 8'h5A);
    frame(12, 32'hFFF, got);
    check(cmd_reg == 8'h5A, "R4", "12-clock frame", cmd_reg, 8'h5A);
    check(val_n == v0, "R4", "no strobe", val_n - v0, 0);

    // R6: daisy-chain 16 clocks
    status_in = 8'hC3;
    frame(16, 32'h1234, got);
    check(got[15:8] == 8'hC3, "R6", "first byte out", got[15:8], 8'hC3);
    check(got[7:0] == 8'h12, "R6", "passed-through byte", got[7:0], 8'h12);
    check(cmd_reg == 8'h34, "R6", "last byte kept", cmd_reg, 8'h34);

    // R5: clocks and data with select high do nothing
    c0 = cap_n; v0 = val_n;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; sclk = 1'b1; repeat (H) @(negedge clk);
      sclk = 1'b0; repeat (H) @(negedge clk);
    end
    check(cmd_reg == 8'h34, "R5", "cmd while idle", cmd_reg, 8'h34);
    check(sdo_oe == 0, "R5", "sdo released", sdo_oe, 0);
    check(cap_n == c0 && val_n == v0, "R5", "idle strobes",
          (cap_n - c0) + (val_n - v0), 0);

    // R8: OR with discrete pins
    pin_en = 4'b0011;
    @(negedge clk);
    check(chan_en == 4'b0111, "R8", "chan_en", chan_en, 4'b0111);
    frame(8, 32'h08, got);
    check(chan_en == 4'b1011, "R8", "chan_en after write", chan_en, 4'b1011);

    // R7: sleep clear and priority over commit
    sleep = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_reg == 0, "R7", "sleep clear", cmd_reg, 0);
    check(chan_en == pin_en, "R7", "pins only", chan_en, pin_en);
    v0 = val_n;
    frame(8, 32'hEE, got);
    check(cmd_reg == 0 && val_n == v0, "R7", "frame during sleep",
          cmd_reg, 0);
    sleep = 1'b0;
    frame(8, 32'h77, got);
    check(cmd_reg == 8'h77, "R3", "after wake", cmd_reg, 8'h77);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule